// File: doc/BRIEF.md
# Guarded Idle Power-Gating Controller

This block decides when a functional unit may be switched off. The first level is an idle predictor. It watches a unit-idle flag and, after a programmable run of consecutive idle cycles, puts the unit to sleep. It then follows each sleep period through two gated phases. In the first phase the period has not yet slept long enough to repay the cost of gating. In the second phase it has passed the break-even length. If the unit is woken before break-even, that is a misprediction that wastes energy.

The second level is a guard. It scores every period into two efficiency counters and a signed savings estimate. Each gated cycle past break-even adds one to the estimate, and each early wake subtracts a programmable penalty. At the end of every evaluation window the guard sets its enable from the sign of the estimate and clears both counters. While the enable is low, the predictor keeps running in shadow. Shadow periods never drive the sleep output, but they are scored in the same way, so a workload that turns favourable re-enables gating by itself.

Top module: `pg_guard_top`

## Requirements
- R1: After reset, `sleep` is 0, `gate_en` is 1, both counters are 0 and `savings` is 0.
- R2: While `gate_en` is 1, `sleep` goes high on the clock edge that completes `idle_thresh` consecutive cycles with `unit_idle` high, and is visible the cycle after that edge.
- R3: A single cycle with `unit_idle` low while ungated restarts the idle run from zero.
- R4: While gated, a cycle with `unit_idle` low (the wake request) returns `sleep` to 0 at the next edge.
- R5: A wake after fewer than `breakeven` gated cycles adds 1 to `cnt_uncomp` and subtracts `miss_penalty` from `savings`.
- R6: A wake after at least `breakeven` gated cycles adds 1 to `cnt_comp`. Each gated cycle beyond the first `breakeven` adds 1 to `savings`.
- R7: On the edge that completes `eval_window` cycles of a window, `gate_en` becomes 1 if the updated `savings` is positive and 0 otherwise. Both counters clear on that edge, and `savings` is retained.
- R8: While `gate_en` is 0, no new period raises `sleep`, but periods are still predicted and scored into the counters and `savings`.
- R9: A period that began while `gate_en` was 0 keeps `sleep` at 0 until it ends, even if `gate_en` rises meanwhile.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unit_idle | input | 1 | Unit has no work this cycle; low while gated is a wake request |
| idle_thresh | input | CFG_W | Consecutive idle cycles required before gating (0 acts as 1) |
| breakeven | input | CFG_W | Gated cycles needed for a period to be compensated |
| miss_penalty | input | PEN_W | Amount subtracted from the estimate per uncompensated period |
| eval_window | input | CFG_W | Cycles per guard evaluation window (0 acts as 1) |
| sleep | output | 1 | Power-gate request to the unit |
| gate_en | output | 1 | Guard enable permitting new gating |
| cnt_comp | output | EV_W | Compensated periods in the current window, saturating |
| cnt_uncomp | output | EV_W | Uncompensated periods in the current window, saturating |
| savings | output | ACC_W | Signed saturating net-savings estimate |

## Verification
The assertions assume that the configuration inputs do not change while a window or a period is in progress. They also assume that `miss_penalty` is far smaller than the range of `savings`, so that one update cannot wrap around. The stimulus changes the configuration only while reset is held, and it uses a penalty of 20 against a 16-bit estimate. `unit_idle` is driven only on falling edges. The sleep and counter checks therefore rely only on values that were stable at the preceding rising edge.

// File: rtl/pg_guard_pkg.sv
package pg_guard_pkg;

    typedef enum logic [1:0] {
        PG_ON     = 2'd0,
        PG_OFF_U  = 2'd1,
        PG_OFF_C  = 2'd2
    } pg_state_e;

endpackage

// File: rtl/pg_idle_fsm.sv
module pg_idle_fsm
    import pg_guard_pkg::*;
#(
    parameter int CFG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             unit_idle,
    input  logic             gate_en,
    input  logic [CFG_W-1:0] idle_thresh,
    input  logic [CFG_W-1:0] breakeven,
    output logic             sleep,
    output logic             ev_extra,
    output logic             ev_comp,
    output logic             ev_uncomp
);

    localparam logic [CFG_W:0] ONE_C = (CFG_W+1)'(1);

    typedef struct packed {
        pg_state_e        st;
        logic             real_gate;
        logic [CFG_W-1:0] idle_cnt;
        logic [CFG_W-1:0] slp_cnt;
    } fsm_s;

    fsm_s q, d;
    logic idle_hit, slp_hit;
    logic [CFG_W-1:0] idle_inc, slp_inc;

    always_comb begin
        d         = q;
        ev_extra  = 1'b0;
        ev_comp   = 1'b0;
        ev_uncomp = 1'b0;
        idle_inc  = (q.idle_cnt == '1) ? q.idle_cnt : q.idle_cnt + 1'b1;
        slp_inc   = (q.slp_cnt == '1) ? q.slp_cnt : q.slp_cnt + 1'b1;
        idle_hit  = ({1'b0, q.idle_cnt} + ONE_C) >= {1'b0, idle_thresh};
        slp_hit   = ({1'b0, q.slp_cnt} + ONE_C) >= {1'b0, breakeven};
        case (q.st)
            PG_ON: begin
                if (unit_idle) begin
                    d.idle_cnt = idle_inc;
                    if (idle_hit) begin
                        d.st        = PG_OFF_U;
                        d.real_gate = gate_en;
                        d.slp_cnt   = '0;
                        d.idle_cnt  = '0;
                    end
                end else begin
                    d.idle_cnt = '0;
                end
            end
            PG_OFF_U: begin
                if (!unit_idle) begin
                    d.st      = PG_ON;
                    ev_uncomp = 1'b1;
                end else begin
                    d.slp_cnt = slp_inc;
                    if (slp_hit) d.st = PG_OFF_C;
                end
            end
            PG_OFF_C: begin
                if (!unit_idle) begin
                    d.st    = PG_ON;
                    ev_comp = 1'b1;
                end else begin
                    ev_extra = 1'b1;
                end
            end
            default: d.st = PG_ON;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st        <= PG_ON;
            q.real_gate <= 1'b0;
            q.idle_cnt  <= '0;
            q.slp_cnt   <= '0;
        end else begin
            q <= d;
        end
    end

    assign sleep = q.real_gate && (q.st != PG_ON);

endmodule

// File: rtl/pg_guard_eval.sv
module pg_guard_eval #(
    parameter int CFG_W = 16,
    parameter int EV_W  = 8,
    parameter int ACC_W = 16,
    parameter int PEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_extra,
    input  logic             ev_comp,
    input  logic             ev_uncomp,
    input  logic [PEN_W-1:0] miss_penalty,
    input  logic [CFG_W-1:0] eval_window,
    output logic             gate_en,
    output logic [EV_W-1:0]  cnt_comp,
    output logic [EV_W-1:0]  cnt_uncomp,
    output logic [ACC_W-1:0] savings
);

    localparam int SUM_W = ACC_W + 2;
    localparam logic [CFG_W:0] ONE_C = (CFG_W+1)'(1);
    localparam logic signed [SUM_W-1:0] MAX_V = $signed({3'b000, {(ACC_W-1){1'b1}}});
    localparam logic signed [SUM_W-1:0] MIN_V = $signed({3'b111, {(ACC_W-1){1'b0}}});

    typedef struct packed {
        logic             en;
        logic [CFG_W-1:0] win;
        logic [EV_W-1:0]  comp;
        logic [EV_W-1:0]  uncomp;
        logic [ACC_W-1:0] acc;
    } grd_s;

    grd_s q, d;
    logic win_hit;
    logic signed [SUM_W-1:0] sum;
    logic signed [SUM_W-1:0] add_v;
    logic signed [SUM_W-1:0] sub_v;

    always_comb begin
        d      = q;
        add_v  = $signed({{(SUM_W-1){1'b0}}, ev_extra});
        sub_v  = ev_uncomp ? $signed({{(SUM_W-PEN_W){1'b0}}, miss_penalty}) : '0;
        sum    = $signed({{2{q.acc[ACC_W-1]}}, q.acc}) + add_v - sub_v;
        if (sum > MAX_V)      d.acc = MAX_V[ACC_W-1:0];
        else if (sum < MIN_V) d.acc = MIN_V[ACC_W-1:0];
        else                  d.acc = sum[ACC_W-1:0];

        win_hit = ({1'b0, q.win} + ONE_C) >= {1'b0, eval_window};
        if (win_hit) begin
            d.win    = '0;
            d.en     = $signed(d.acc) > 0;
            d.comp   = '0;
            d.uncomp = '0;
        end else begin
            d.win = q.win + 1'b1;
            if (ev_comp && q.comp != '1)     d.comp   = q.comp + 1'b1;
            if (ev_uncomp && q.uncomp != '1) d.uncomp = q.uncomp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.en     <= 1'b1;
            q.win    <= '0;
            q.comp   <= '0;
            q.uncomp <= '0;
            q.acc    <= '0;
        end else begin
            q <= d;
        end
    end

    assign gate_en    = q.en;
    assign cnt_comp   = q.comp;
    assign cnt_uncomp = q.uncomp;
    assign savings    = q.acc;

endmodule

// File: rtl/pg_guard_top.sv
module pg_guard_top #(
    parameter int CFG_W = 16,
    parameter int EV_W  = 8,
    parameter int ACC_W = 16,
    parameter int PEN_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    unit_idle,
    input  logic [CFG_W-1:0]        idle_thresh,
    input  logic [CFG_W-1:0]        breakeven,
    input  logic [PEN_W-1:0]        miss_penalty,
    input  logic [CFG_W-1:0]        eval_window,
    output logic                    sleep,
    output logic                    gate_en,
    output logic [EV_W-1:0]         cnt_comp,
    output logic [EV_W-1:0]         cnt_uncomp,
    output logic signed [ACC_W-1:0] savings
);

    logic ev_extra, ev_comp, ev_uncomp;
    logic [ACC_W-1:0] acc_w;

    pg_idle_fsm #(.CFG_W(CFG_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .unit_idle   (unit_idle),
        .gate_en     (gate_en),
        .idle_thresh (idle_thresh),
        .breakeven   (breakeven),
        .sleep       (sleep),
        .ev_extra    (ev_extra),
        .ev_comp     (ev_comp),
        .ev_uncomp   (ev_uncomp)
    );

    pg_guard_eval #(
        .CFG_W (CFG_W),
        .EV_W  (EV_W),
        .ACC_W (ACC_W),
        .PEN_W (PEN_W)
    ) u_eval (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev_extra     (ev_extra),
        .ev_comp      (ev_comp),
        .ev_uncomp    (ev_uncomp),
        .miss_penalty (miss_penalty),
        .eval_window  (eval_window),
        .gate_en      (gate_en),
        .cnt_comp     (cnt_comp),
        .cnt_uncomp   (cnt_uncomp),
        .savings      (acc_w)
    );

    assign savings = $signed(acc_w);

endmodule

// File: rtl/pg_guard_chk.sv
module pg_guard_chk #(
    parameter int EV_W  = 8,
    parameter int ACC_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    unit_idle,
    input logic                    sleep,
    input logic                    gate_en,
    input logic [EV_W-1:0]         cnt_comp,
    input logic [EV_W-1:0]         cnt_uncomp,
    input logic signed [ACC_W-1:0] savings
);

    // R2
    sleep_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep) |-> ($past(gate_en) && $past(unit_idle)));

    // R4
    wake_on_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep) |-> !$past(unit_idle));

    // R5
    miss_on_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_uncomp == $past(cnt_uncomp) + 1'b1) |-> !$past(unit_idle));

    // R6
    comp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_comp != $past(cnt_comp)) |->
            (cnt_comp == $past(cnt_comp) + 1'b1 || cnt_comp == '0));

    // R7
    enable_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gate_en) |-> (gate_en == (savings > 0)));

endmodule

bind pg_guard_top pg_guard_chk #(.EV_W(EV_W), .ACC_W(ACC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .unit_idle  (unit_idle),
    .sleep      (sleep),
    .gate_en    (gate_en),
    .cnt_comp   (cnt_comp),
    .cnt_uncomp (cnt_uncomp),
    .savings    (savings)
);

// File: tb/pg_guard_top_tb.sv
module pg_guard_top_tb;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        unit_idle = 1'b0;
    logic [15:0] idle_thresh = 16'd4;
    logic [15:0] breakeven = 16'd10;
    logic [7:0]  miss_penalty = 8'd20;
    logic [15:0] eval_window = 16'hFFFF;
    logic        sleep, gate_en;
    logic [7:0]  cnt_comp, cnt_uncomp;
    logic signed [15:0] savings;

    int total = 0;
    int bad = 0;

    always #(CLK_P/2) clk = ~clk;

    pg_guard_top u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .unit_idle    (unit_idle),
        .idle_thresh  (idle_thresh),
        .breakeven    (breakeven),
        .miss_penalty (miss_penalty),
        .eval_window  (eval_window),
        .sleep        (sleep),
        .gate_en      (gate_en),
        .cnt_comp     (cnt_comp),
        .cnt_uncomp   (cnt_uncomp),
        .savings      (savings)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [15:0] win);
        rst_n       = 1'b0;
        unit_idle   = 1'b0;
        eval_window = win;
        step(2);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset(16'hFFFF);
        chk("R1 sleep", sleep, 0);
        chk("R1 gate_en", gate_en, 1);
        chk("R1 cnt_comp", cnt_comp, 0);
        chk("R1 cnt_uncomp", cnt_uncomp, 0);
        chk("R1 savings", savings, 0);
    endtask

    task automatic t_thresh_and_wake();
        do_reset(16'hFFFF);
        unit_idle = 1'b1;
        step(3);
        chk("R2 before threshold", sleep, 0);
        step(1);
        chk("R2 at threshold", sleep, 1);
        unit_idle = 1'b0;
        step(1);
        chk("R4 wake", sleep, 0);
        chk("R5 uncomp count", cnt_uncomp, 1);
        chk("R5 penalty", savings, -20);
    endtask

    task automatic t_streak();
        do_reset(16'hFFFF);
        unit_idle = 1'b1;
        step(3);
        unit_idle = 1'b0;
        step(1);
        unit_idle = 1'b1;
        step(3);
        chk("R3 run restarted", sleep, 0);
        step(1);
        chk("R3 gate after fresh run", sleep, 1);
    endtask

    task automatic t_breakeven();
        do_reset(16'hFFFF);
        unit_idle = 1'b1;
        step(4);
        step(9);
        unit_idle = 1'b0;
        step(1);
        chk("R5 one short of breakeven", cnt_uncomp, 1);
        chk("R6 no comp when short", cnt_comp, 0);
        unit_idle = 1'b1;
        step(14);
        unit_idle = 1'b0;
        step(1);
        chk("R6 exact breakeven comp", cnt_comp, 1);
        chk("R6 no extra at breakeven", savings, -20);
        unit_idle = 1'b1;
        step(19);
        chk("R6 still gated", sleep, 1);
        unit_idle = 1'b0;
        step(1);
        chk("R6 comp count", cnt_comp, 2);
        chk("R6 extra cycles credited", savings, -15);
    endtask

    task automatic t_window();
        do_reset(16'd40);
        unit_idle = 1'b1;
        step(4);
        step(2);
        unit_idle = 1'b0;
        step(1);
        step(32);
        chk("R7 enable before window end", gate_en, 1);
        chk("R7 count before window end", cnt_uncomp, 1);
        step(1);
        chk("R7 disable on negative", gate_en, 0);
        chk("R7 counters cleared", cnt_uncomp, 0);
        chk("R7 savings kept", savings, -20);
        unit_idle = 1'b1;
        step(4);
        chk("R8 no gating while disabled", sleep, 0);
        step(35);
        chk("R8 shadow scored", savings, 5);
        chk("R8 still disabled", gate_en, 0);
        step(1);
        chk("R7 re-enable on positive", gate_en, 1);
        chk("R7 updated savings", savings, 6);
        chk("R9 shadow period ungated", sleep, 0);
        unit_idle = 1'b0;
        step(1);
        chk("R8 shadow comp counted", cnt_comp, 1);
        chk("R9 sleep low at shadow end", sleep, 0);
        unit_idle = 1'b1;
        step(4);
        chk("R2 gating after re-enable", sleep, 1);
    endtask

    initial begin
        t_reset();
        t_thresh_and_wake();
        t_streak();
        t_breakeven();
        t_window();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule